// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the loading end of a single-wire serial configuration link. It works from the system clock and decides on its own how long the external memory chain must be clocked. At power-up, and on every reconfiguration, it first holds an active-low memory-reset line (`init_n_o`) low for a fixed number of cycles. This resets the address counters of the external memories. It then samples the mode inputs, once, at the end of that window.

When the mode inputs are all zero, the block drives a divided-down configuration clock and reads one data bit on every rising edge of that clock. It looks for a sync header and then reads a length field. After that it issues exactly the requested number of further clock pulses and raises `done_o`. While `done_o` is low it serves as the active-low enable of the first memory in the chain. When `done_o` rises, the chain is switched off.

The DONE line is open-drain in use, and the level seen on it comes back in on `done_in_i`. A low on that line after completion starts a new configuration. The `restart_n_i` input aborts any activity and starts over. If the sync header is not found within a bounded number of clock pulses, the block raises `err_o` and stops.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset release, and after any restart, `init_n_o` stays low for INIT_CYCLES system cycles. During that time `cclk_o` and `done_o` are low.
- R2: The mode inputs are read once, in the last cycle of the init window. Any value other than 3'b000 leaves the block idle until the next restart: `init_n_o` high, no clock pulses, `done_o` and `err_o` low.
- R3: While loading, `cclk_o` has a period of CLK_DIV system cycles and is high for CLK_DIV/2 of them. Data is sampled at the system edge on which `cclk_o` rises.
- R4: The sync header is at least PRE_ONES consecutive 1 bits followed by the bits 0,0,1,0 in that order. A run of fewer 1 bits before 0,0,1,0 is not accepted.
- R5: A LEN_W-bit length count follows the header, most significant bit first. After its last bit, exactly that many further clock pulses are issued and then `done_o` goes high. A count of zero raises `done_o` right after the header.
- R6: Once `done_o` is high, `cclk_o` stays low and shows no further rising edge.
- R7: A low on `done_in_i` while `done_o` is high drives `init_n_o` low on the next cycle and starts a full new configuration.
- R8: A low on `restart_n_i` in any state drives `init_n_o` low on the next cycle and stops the clock. The init window is held while the input stays low.
- R9: If no sync header is found within SYNC_LIMIT clock pulses, `err_o` goes high after exactly that many pulses. `done_o` stays low and the clock stops until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_n_i | input | 1 | Active-low restart request, synchronous |
| mode_i | input | 3 | Mode select, 3'b000 selects serial master loading |
| din_i | input | 1 | Serial configuration data from the memory chain |
| done_in_i | input | 1 | Level observed on the wired DONE line |
| cclk_o | output | 1 | Generated configuration clock |
| init_n_o | output | 1 | Active-low reset for external memory address counters |
| done_o | output | 1 | Loading complete; low acts as the memory chain enable |
| err_o | output | 1 | Sync header not found in time |

## Verification
The bench models the memory chain as a bit stream whose read pointer advances on each rising edge of `cclk_o` and is cleared by `init_n_o`. This lets the pointer at completion be compared with the expected total number of pulses.

The streams cover several cases:
- an exact eight-bit run of ones with a mid-sized length, which tests header recognition and pulse counting;
- a zero length, which tests the direct exit to DONE;
- leading zeros with a longer run of ones, which shows that extra ones and junk before them are tolerated;
- a seven-bit run, which must not sync and must end in the timeout fault.

Reconfiguration by pulling DONE low, an abort in the middle of the payload, and a non-master mode value each show whether the pointer reset and the restart path truly start over from the first bit.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_SERIAL_MASTER = 3'b000;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_HUNT  = 3'd1,
    ST_LEN   = 3'd2,
    ST_LOAD  = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5,
    ST_IDLE  = 3'd6
  } ldr_state_t;

endpackage

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic cclk_o,
  output logic tick_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cclk_q, cclk_d;

  always_comb begin
    cnt_d = '0;
    if (en_i) begin
      cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
    cclk_d = en_i && (cnt_d >= CW'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cclk_q <= cclk_d;
    end
  end

  // rising edge of cclk happens at the same edge this tick is seen
  assign tick_o = en_i && (cnt_q == CW'(HALF - 1));
  assign cclk_o = cclk_q;

  a_r3_rise_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $past(en_i));

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser #(
  parameter int PRE_ONES = 8,
  parameter int LEN_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             din_i,
  input  logic             hunt_en_i,
  input  logic             len_en_i,
  output logic             sync_hit_o,
  output logic             len_last_o,
  output logic [LEN_W-1:0] len_val_o
);
  localparam int PW  = PRE_ONES + 4;
  localparam int BCW = $clog2(LEN_W);
  localparam logic [PW-1:0]  PATTERN  = {{PRE_ONES{1'b1}}, 4'b0010};
  localparam logic [BCW-1:0] BIT_LAST = BCW'(LEN_W - 1);

  logic [PW-2:0]    win_q, win_d;
  logic [LEN_W-2:0] len_q, len_d;
  logic [BCW-1:0]   bcnt_q, bcnt_d;

  assign sync_hit_o = hunt_en_i && tick_i && ({win_q, din_i} == PATTERN);
  assign len_last_o = len_en_i && tick_i && (bcnt_q == BIT_LAST);
  assign len_val_o  = {len_q, din_i};

  always_comb begin
    win_d  = win_q;
    len_d  = len_q;
    bcnt_d = bcnt_q;
    if (clr_i) begin
      win_d  = '0;
      len_d  = '0;
      bcnt_d = '0;
    end else begin
      if (hunt_en_i && tick_i) win_d = {win_q[PW-3:0], din_i};
      if (len_en_i && tick_i) begin
        len_d  = {len_q[LEN_W-3:0], din_i};
        bcnt_d = (bcnt_q == BIT_LAST) ? '0 : bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      len_q  <= '0;
      bcnt_q <= '0;
    end else begin
      win_q  <= win_d;
      len_q  <= len_d;
      bcnt_q <= bcnt_d;
    end
  end

  a_r5_len_starts_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_en_i) |-> (bcnt_q == '0));

endmodule

// File: rtl/cfg_pulse_ctr.sv
module cfg_pulse_ctr #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == W'(1));

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int INIT_CYCLES = 16,
  parameter int SYNC_LIMIT  = 1024,
  parameter int PRE_ONES    = 8,
  parameter int LEN_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_n_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              din_i,
  input  logic              done_in_i,
  output logic              cclk_o,
  output logic              init_n_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int ICW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam int TOW = $clog2(SYNC_LIMIT + 1);
  localparam logic [ICW-1:0] IC_LAST = ICW'(INIT_CYCLES - 1);

  ldr_state_t       state_q, state_d;
  logic [ICW-1:0]   icnt_q, icnt_d;
  logic             clk_en, tick;
  logic             sync_hit, len_last, to_last, ld_last;
  logic [LEN_W-1:0] len_val;
  logic             init_end, go_hunt, ld_load;

  assign clk_en   = (state_q == ST_HUNT) || (state_q == ST_LEN) || (state_q == ST_LOAD);
  assign init_end = (state_q == ST_INIT) && restart_n_i && (icnt_q == IC_LAST);
  assign go_hunt  = init_end && (mode_i == MODE_SERIAL_MASTER);
  assign ld_load  = len_last && (len_val != '0);

  cfg_cclk_gen #(.DIV(CLK_DIV)) u_cclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (clk_en),
    .cclk_o (cclk_o),
    .tick_o (tick)
  );

  cfg_hdr_parser #(.PRE_ONES(PRE_ONES), .LEN_W(LEN_W)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (state_q == ST_INIT),
    .tick_i     (tick),
    .din_i      (din_i),
    .hunt_en_i  (state_q == ST_HUNT),
    .len_en_i   (state_q == ST_LEN),
    .sync_hit_o (sync_hit),
    .len_last_o (len_last),
    .len_val_o  (len_val)
  );

  cfg_pulse_ctr #(.W(TOW)) u_sync_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (go_hunt),
    .load_val_i (TOW'(SYNC_LIMIT)),
    .dec_i      ((state_q == ST_HUNT) && tick && !sync_hit),
    .last_o     (to_last)
  );

  cfg_pulse_ctr #(.W(LEN_W)) u_load_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_load),
    .load_val_i (len_val),
    .dec_i      ((state_q == ST_LOAD) && tick),
    .last_o     (ld_last)
  );

  always_comb begin
    state_d = state_q;
    if (!restart_n_i) begin
      state_d = ST_INIT;
    end else begin
      case (state_q)
        ST_INIT:  if (init_end) state_d = go_hunt ? ST_HUNT : ST_IDLE;
        ST_HUNT:  if (tick) begin
                    if (sync_hit)     state_d = ST_LEN;
                    else if (to_last) state_d = ST_FAULT;
                  end
        ST_LEN:   if (len_last) state_d = ld_load ? ST_LOAD : ST_DONE;
        ST_LOAD:  if (tick && ld_last) state_d = ST_DONE;
        ST_DONE:  if (!done_in_i) state_d = ST_INIT;
        default:  state_d = state_q;
      endcase
    end
    icnt_d = '0;
    if ((state_q == ST_INIT) && restart_n_i && !init_end) icnt_d = icnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      icnt_q  <= '0;
    end else begin
      state_q <= state_d;
      icnt_q  <= icnt_d;
    end
  end

  assign init_n_o = (state_q != ST_INIT);
  assign done_o   = (state_q == ST_DONE);
  assign err_o    = (state_q == ST_FAULT);

  a_r1_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n_o && $past(!init_n_o)) |-> (!cclk_o && !done_o));
  a_r2_other_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(init_n_o) && ($past(mode_i) != MODE_SERIAL_MASTER)) |-> !clk_en);
  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> !cclk_o);
  a_r7_done_pull_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !done_in_i) |=> !init_n_o);
  a_r8_restart_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_n_i |=> !init_n_o);
  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && $past(err_o)) |-> (!cclk_o && !done_o));

endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  localparam int IC = 4;
  localparam int SL = 64;

  logic       clk = 1'b0;
  logic       rst_n, restart_n, force_low;
  logic [2:0] mode;
  logic       cclk, init_n, done, err, din, done_line;

  logic stream [0:255];
  int   nbits;
  int   ptr;
  int   checks = 0;
  int   fails  = 0;

  always #5 clk = ~clk;

  assign done_line = done & ~force_low;
  assign din = (ptr < nbits) ? stream[ptr] : 1'b1;

  // memory chain model: pointer advances per cclk pulse, cleared by init
  always @(posedge cclk or negedge init_n) begin
    if (!init_n) ptr <= 0;
    else         ptr <= ptr + 1;
  end

  cfg_serial_loader #(
    .CLK_DIV(4), .INIT_CYCLES(IC), .SYNC_LIMIT(SL), .PRE_ONES(8), .LEN_W(24)
  ) uut (
    .clk(clk), .rst_n(rst_n), .restart_n_i(restart_n), .mode_i(mode),
    .din_i(din), .done_in_i(done_line), .cclk_o(cclk), .init_n_o(init_n),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input int zeros, input int ones, input int len);
    int idx = 0;
    for (int i = 0; i < zeros; i++) begin stream[idx] = 1'b0; idx++; end
    for (int i = 0; i < ones; i++)  begin stream[idx] = 1'b1; idx++; end
    stream[idx] = 1'b0; stream[idx+1] = 1'b0; stream[idx+2] = 1'b1; stream[idx+3] = 1'b0;
    idx += 4;
    for (int b = 23; b >= 0; b--) begin stream[idx] = len[b]; idx++; end
    nbits = idx;
  endtask

  task automatic pulse_restart();
    @(negedge clk) restart_n = 1'b0;
    @(negedge clk) restart_n = 1'b1;
  endtask

  task automatic expect_load(input string req, input int pulses);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
    chk(done === 1'b1, req, int'(done), 1);
    chk(err === 1'b0, req, int'(err), 0);
    chk(ptr == pulses, req, ptr, pulses);
    repeat (20) @(negedge clk);
    chk(ptr == pulses, "R6", ptr, pulses);
    chk(cclk === 1'b0, "R6", int'(cclk), 0);
  endtask

  // R1 and R3 and R5: reset window, clock shape, basic load
  task automatic t_reset_and_basic();
    time t0, t1, t2;
    build(0, 8, 20);
    rst_n = 1'b0; restart_n = 1'b1; mode = 3'b000; force_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(init_n === 1'b0, "R1", int'(init_n), 0);
    chk(cclk === 1'b0 && done === 1'b0, "R1", int'(cclk), 0);
    rst_n = 1'b1;
    for (int k = 1; k < IC; k++) begin
      @(negedge clk);
      chk(init_n === 1'b0, "R1", int'(init_n), 0);
    end
    @(negedge clk);
    chk(init_n === 1'b1, "R1", int'(init_n), 1);
    @(posedge cclk) t0 = $time;
    @(negedge cclk) t1 = $time;
    @(posedge cclk) t2 = $time;
    chk((t1 - t0) == 20, "R3 high", int'((t1 - t0) / 10), 2);
    chk((t2 - t0) == 40, "R3 period", int'((t2 - t0) / 10), 4);
    expect_load("R5", 36 + 20);
  endtask

  // R7: external low on DONE line reconfigures from the first bit
  task automatic t_done_pull();
    build(0, 8, 9);
    @(negedge clk) force_low = 1'b1;
    @(negedge clk) force_low = 1'b0;
    chk(init_n === 1'b0, "R7", int'(init_n), 0);
    chk(ptr == 0, "R7", ptr, 0);
    expect_load("R7", 36 + 9);
  endtask

  // R5: zero length finishes right after the header
  task automatic t_zero_len();
    build(0, 8, 0);
    pulse_restart();
    expect_load("R5 zero", 36);
  endtask

  // R4: junk zeros and a long run of ones before the pattern
  task automatic t_long_preamble();
    build(5, 12, 5);
    pulse_restart();
    expect_load("R4", 5 + 12 + 28 + 5);
  endtask

  // R8: abort in the middle of the payload, then a clean full load
  task automatic t_abort();
    build(0, 8, 40);
    pulse_restart();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ptr >= 45) break;
    end
    restart_n = 1'b0;
    @(negedge clk);
    chk(init_n === 1'b0, "R8", int'(init_n), 0);
    chk(ptr == 0, "R8", ptr, 0);
    @(negedge clk);
    chk(cclk === 1'b0, "R8", int'(cclk), 0);
    @(negedge clk) restart_n = 1'b1;
    expect_load("R8", 36 + 40);
  endtask

  // R9 and R4: seven ones never sync, fault after SL pulses
  task automatic t_timeout();
    build(0, 7, 0);
    pulse_restart();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
    chk(err === 1'b1, "R9", int'(err), 1);
    chk(done === 1'b0, "R4", int'(done), 0);
    chk(ptr == SL, "R9", ptr, SL);
    repeat (20) @(negedge clk);
    chk(ptr == SL && cclk === 1'b0, "R9", ptr, SL);
  endtask

  // R2: non-master mode stays idle, master mode recovers
  task automatic t_mode();
    mode = 3'b010;
    pulse_restart();
    repeat (60) @(negedge clk);
    chk(init_n === 1'b1, "R2", int'(init_n), 1);
    chk(ptr == 0, "R2", ptr, 0);
    chk(done === 1'b0 && err === 1'b0 && cclk === 1'b0, "R2", int'(done), 0);
    mode = 3'b000;
    build(0, 8, 3);
    pulse_restart();
    expect_load("R2", 36 + 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_and_basic();
    t_done_pull();
    t_zero_len();
    t_long_preamble();
    t_abort();
    t_timeout();
    t_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule